// File: doc/BRIEF.md
# Selectable Duty-Cycle Clock Divider

This block divides an input clock by an integer ratio and produces one divided clock whose high time is set by a two-bit mode select. In the narrow mode the output is high for one input cycle in each period. In the wide mode it is low for one input cycle. In the even-split mode the output has a 50% duty cycle for every ratio. For an odd ratio this needs a half-cycle extension, which a register clocked on the falling edge of the input clock provides.

A phase counter counts from zero to the active ratio minus one and then wraps. The ratio and the mode are latched only on a wrap, so a change made partway through a period applies from the next period boundary. Ratios below two run as two. An asynchronous active-low reset clears the counter and holds the output low. The first input rising edge after reset is released starts a new period, and the output goes high on that edge.

Top module: `duty_clk_divider`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low and the phase counter holds zero.
- R2: `clk_out` goes high on the first rising edge of `clk_in` after `rst_n` is released. That edge starts phase 0 of a period.
- R3: Each output period lasts exactly N input cycles, where N is the active ratio. The output rises at the start of phase 0.
- R4: With `duty_sel` = 2'b00 (narrow), `clk_out` is high during phase 0 only. For N = 3 that is 1 cycle high and 2 cycles low.
- R5: With `duty_sel` = 2'b01 (wide), `clk_out` is low during phase N-1 only. For N = 3 that is 2 cycles high and 1 cycle low.
- R6: With `duty_sel` = 2'b10 and an even N, `clk_out` is high during phases 0 to N/2-1, using rising-edge logic only.
- R7: With `duty_sel` = 2'b10 and an odd N, `clk_out` is high for phases 0 to (N-1)/2-1 and also for the first half of phase (N-1)/2. It falls on the falling edge of `clk_in`. For N = 3 this gives 1.5 cycles high and 1.5 cycles low.
- R8: A `div_n` value of 0 or 1 is treated as N = 2.
- R9: `div_n` and `duty_sel` are latched only when a period starts. Changes during a period take effect at the next period boundary.
- R10: `duty_sel` = 2'b11 behaves the same as 2'b10 (even split).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_n | input | W | Requested division ratio |
| duty_sel | input | 2 | Duty mode: 00 narrow, 01 wide, 1x even split |
| clk_out | output | 1 | Divided clock |

## Verification
A phase counter that skips a value or wraps late makes the period one cycle longer or shorter. A wrongly latched ratio does the same. Either fault shows in the output waveform within one period of the fault. If the threshold decode is wrong, the high time is off by at least one phase on the first period after the mode is latched. If the half-cycle stage is missing or stuck, an odd even-split period loses its extra half cycle, or an extra half cycle appears in the other modes. The bench samples the output once in each half of every input cycle, so it sees such a fault in the same cycle as the faulty edge.

// File: rtl/duty_clk_divider_pkg.sv
package duty_clk_divider_pkg;

  typedef enum logic [1:0] {
    MODE_NARROW = 2'b00,
    MODE_WIDE   = 2'b01,
    MODE_EVEN   = 2'b10,
    MODE_EVEN_B = 2'b11
  } duty_mode_t;

  localparam int unsigned MIN_RATIO = 2;

endpackage

// File: rtl/divclk_phase_counter.sv
module divclk_phase_counter
  import duty_clk_divider_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [W-1:0]     div_n,
  input  logic [1:0]       duty_sel,
  output logic [W-1:0]     cnt_q,
  output logic [W-1:0]     nact_q,
  output duty_mode_t       mact_q,
  output logic             run_q,
  output logic [W-1:0]     cnt_nx,
  output logic [W-1:0]     nact_nx,
  output duty_mode_t       mact_nx
);

  localparam logic [W-1:0] RATIO_FLOOR = W'(MIN_RATIO);
  localparam logic [W-1:0] ONE         = W'(1);

  logic [W-1:0] n_clean;
  logic         wrap;

  always_comb begin
    n_clean = (div_n < RATIO_FLOOR) ? RATIO_FLOOR : div_n;
    wrap    = !run_q || (cnt_q == (nact_q - ONE));
    if (wrap) begin
      cnt_nx  = '0;
      nact_nx = n_clean;
      mact_nx = duty_mode_t'(duty_sel);
    end else begin
      cnt_nx  = cnt_q + ONE;
      nact_nx = nact_q;
      mact_nx = mact_q;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      nact_q <= RATIO_FLOOR;
      mact_q <= MODE_NARROW;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      nact_q <= nact_nx;
      mact_q <= mact_nx;
      run_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/divclk_duty_decode.sv
module divclk_duty_decode
  import duty_clk_divider_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] phase,
  input  logic [W-1:0] ratio,
  input  duty_mode_t   mode,
  output logic         rise_level,
  output logic         odd_split
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] high_len;

  always_comb begin
    odd_split = 1'b0;
    unique case (mode)
      MODE_NARROW: high_len = ONE;
      MODE_WIDE:   high_len = ratio - ONE;
      default: begin
        high_len  = ratio >> 1;
        odd_split = ratio[0];
      end
    endcase
    rise_level = (phase < high_len);
  end

endmodule

// File: rtl/divclk_half_stage.sv
module divclk_half_stage #(
  parameter bit HALF_EN = 1'b1
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic rise_q,
  input  logic odd_q,
  output logic neg_q,
  output logic clk_out
);

  generate
    if (HALF_EN) begin : g_half
      logic neg_nx;

      always_comb neg_nx = rise_q & odd_q;

      always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= neg_nx;
      end
    end else begin : g_nohalf
      assign neg_q = 1'b0;
    end
  endgenerate

  assign clk_out = rise_q | neg_q;

endmodule

// File: rtl/duty_clk_divider.sv
module duty_clk_divider
  import duty_clk_divider_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic [W-1:0] div_n,
  input  logic [1:0]   duty_sel,
  output logic         clk_out
);

  logic [W-1:0] cnt_q, nact_q, cnt_nx, nact_nx;
  duty_mode_t   mact_q, mact_nx;
  logic         run_q;
  logic         rise_nx, odd_nx;
  logic         rise_q, odd_q, neg_q;

  divclk_phase_counter #(.W(W)) u_cnt (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .div_n    (div_n),
    .duty_sel (duty_sel),
    .cnt_q    (cnt_q),
    .nact_q   (nact_q),
    .mact_q   (mact_q),
    .run_q    (run_q),
    .cnt_nx   (cnt_nx),
    .nact_nx  (nact_nx),
    .mact_nx  (mact_nx)
  );

  divclk_duty_decode #(.W(W)) u_dec (
    .phase      (cnt_nx),
    .ratio      (nact_nx),
    .mode       (mact_nx),
    .rise_level (rise_nx),
    .odd_split  (odd_nx)
  );

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      rise_q <= rise_nx;
      odd_q  <= odd_nx;
    end
  end

  divclk_half_stage #(.HALF_EN(1'b1)) u_half (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .rise_q  (rise_q),
    .odd_q   (odd_q),
    .neg_q   (neg_q),
    .clk_out (clk_out)
  );

endmodule

// File: rtl/duty_clk_divider_chk.sv
module duty_clk_divider_chk
  import duty_clk_divider_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_in,
  input logic         rst_n,
  input logic         clk_out,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] nact_q,
  input duty_mode_t   mact_q,
  input logic         run_q,
  input logic         rise_q,
  input logic         neg_q
);

  // R1: held low and cleared while reset is asserted
  a_r1_reset_low: assert property (@(posedge clk_in)
    !rst_n |-> (!clk_out && cnt_q == '0));

  // R3: phase never reaches the active ratio
  a_r3_phase_range: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt_q < nact_q);

  // R8: active ratio is never below two
  a_r8_ratio_floor: assert property (@(posedge clk_in) disable iff (!rst_n)
    nact_q >= W'(MIN_RATIO));

  // R9: ratio and mode only change at a period start
  a_r9_latch_at_wrap: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_q && cnt_q != '0) |-> ($stable(nact_q) && $stable(mact_q)));

  // R4: narrow mode is high in phase 0 only
  a_r4_narrow: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_q && mact_q == MODE_NARROW) |-> (rise_q == (cnt_q == '0)));

  // R5: wide mode is low in the last phase only
  a_r5_wide: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_q && mact_q == MODE_WIDE) |-> (rise_q == (cnt_q != nact_q - W'(1))));

  // R7: the half-cycle extension only follows a high rising-edge level
  a_r7_half_follows: assert property (@(posedge clk_in) disable iff (!rst_n)
    neg_q |-> rise_q);

endmodule

bind duty_clk_divider duty_clk_divider_chk #(.W(W)) u_chk (
  .clk_in  (clk_in),
  .rst_n   (rst_n),
  .clk_out (clk_out),
  .cnt_q   (cnt_q),
  .nact_q  (nact_q),
  .mact_q  (mact_q),
  .run_q   (run_q),
  .rise_q  (rise_q),
  .neg_q   (neg_q)
);

// File: tb/duty_clk_divider_test.sv
module duty_clk_divider_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] div_n;
  logic [1:0]   duty_sel;
  logic         clk_out;

  always #4 clk = ~clk;

  duty_clk_divider #(.W(W)) uut (
    .clk_in   (clk),
    .rst_n    (rst_n),
    .div_n    (div_n),
    .duty_sel (duty_sel),
    .clk_out  (clk_out)
  );

  int  n_chk, n_fail;
  int  ph, nact, mact;
  bit  run, cur_rise, cur_odd, neg_exp;
  bit  finished;

  function automatic int high_len(int n, int m);
    if (m == 0)      return 1;
    else if (m == 1) return n - 1;
    else             return n / 2;
  endfunction

  task automatic check(bit got, bit exp, string tag, string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // one input cycle: model update at the edge, then sample both halves
  task automatic step(string tag);
    int n_in = (int'(div_n) < 2) ? 2 : int'(div_n);
    int m    = int'(duty_sel);
    @(posedge clk);
    if (!run || ph == nact - 1) begin
      ph = 0; nact = n_in; mact = m;
    end else begin
      ph++;
    end
    run      = 1'b1;
    neg_exp  = cur_rise & cur_odd;
    cur_rise = (ph < high_len(nact, mact));
    cur_odd  = (mact >= 2) && (nact % 2 == 1);
    #2 check(clk_out, cur_rise | neg_exp, tag, "first half");
    #4 check(clk_out, cur_rise, tag, "second half");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    run = 1'b0; cur_rise = 1'b0; cur_odd = 1'b0; ph = 0; nact = 2; mact = 0;
    repeat (3) begin
      @(negedge clk);
      #1 check(clk_out, 1'b0, "R1", "reset level");
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_cycles(int k, string tag);
    for (int i = 0; i < k; i++) step(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; div_n = 8'd3; duty_sel = 2'b00;
    run = 0; cur_rise = 0; cur_odd = 0; ph = 0; nact = 2; mact = 0;

    do_reset();
    step("R2");
    run_cycles(8, "R4");

    duty_sel = 2'b01; run_cycles(9, "R5");
    div_n = 8'd6;     run_cycles(12, "R3");
    duty_sel = 2'b10; div_n = 8'd4; run_cycles(12, "R6");
    div_n = 8'd3;     run_cycles(12, "R7");
    div_n = 8'd5;     run_cycles(15, "R7");
    duty_sel = 2'b11; run_cycles(15, "R10");
    div_n = 8'd0; duty_sel = 2'b00; run_cycles(8, "R8");
    div_n = 8'd1; duty_sel = 2'b01; run_cycles(8, "R8");

    // reset in the middle of an odd split period, new mode ready at release
    div_n = 8'd7; duty_sel = 2'b10; run_cycles(10, "R7");
    rst_n = 1'b0;
    #1 check(clk_out, 1'b0, "R1", "async reset");
    do_reset();
    step("R2");
    run_cycles(20, "R7");

    div_n = 8'd255; duty_sel = 2'b00; run_cycles(520, "R3");

    // random mix of ratio and mode changes at arbitrary phases
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) div_n = 8'($urandom_range(0, 13));
      if ($urandom_range(0, 15) == 0) duty_sel = 2'($urandom_range(0, 3));
      step("R9");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule